// File: doc/BRIEF.md
# Two-Beat Double-Rate Static Memory with Split Read and Write Ports

This block is a synchronous word store with its own read port and its own write port. Each access moves a burst of two data beats, one in each half of a reference clock period. The block runs from an internal clock at twice the reference rate and produces the reference clock itself as `kref`. A clock edge that finds `kref` low is a reference rising edge, and an edge that finds it high is a reference falling edge. The selects, the burst address and the first write beat are taken on a rising edge. The second write beat is taken on the falling edge that follows.

A burst address `A` names the word pair `2A` (first beat) and `2A+1` (second beat). Write beats can be masked per byte lane. Read data comes back with a fixed latency of one and a half reference cycles. Outside a read burst the data output floats.

The read side has a fixed latency and no back-pressure, so it carries no ready signal. `rdata_oe` acts as the valid flag, and the consumer must take each beat in the half-cycle it is shown. The same holds for the write side: every beat presented under an active write select is consumed.

Top module: `ddr2b_sram`

## Requirements
- R1: While reset is held, `rdata_oe` is 0 and `rdata_out` floats (all Z). After reset `kref` is 0, the first clock edge is a reference rising edge, and `kref` inverts on every edge from then on.
- R2: `rd_sel_n` is active low and is taken only on a reference rising edge. When it is 1, no burst follows: `rdata_oe` stays 0 and `rdata_out` floats.
- R3: For a read taken at rising edge E0, word `2A` appears on `rdata_out` after edge E0+3 (the next falling edge of the following cycle). Word `2A+1` follows after edge E0+4. `rdata_oe` is 1 for exactly those two half-cycles.
- R4: Reads issued in consecutive reference cycles produce an unbroken output stream of four beats, in order.
- R5: `wr_sel_n` is active low and is taken on a reference rising edge. When it is 1, no word changes, whatever the data and lane enables.
- R6: The first write beat is taken at the rising edge and goes to word `2A`. The second beat is taken at the following falling edge and goes to word `2A+1`.
- R7: `lane_wen_n` is active low per lane and is sampled separately with each beat. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A masked lane keeps its old contents in that beat only.
- R8: A write with both lanes masked in both beats leaves both words unchanged.
- R9: A read and a write to the same burst address in the same rising edge return the data held before the write, in both beats.
- R10: Data written in one reference cycle is returned by a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read select, active low, taken at reference rising edge |
| wr_sel_n | input | 1 | Write select, active low, taken at reference rising edge |
| burst_addr | input | 4 | Burst address, names words 2A and 2A+1 |
| wdata_in | input | 18 | Write data, beat 0 at rising edge, beat 1 at falling edge |
| lane_wen_n | input | 2 | Per-lane write enables, active low, per beat |
| rdata_out | output | 18 | Read data, Z when not driving |
| rdata_oe | output | 1 | High while `rdata_out` carries a valid beat |
| kref | output | 1 | Generated reference clock |

## Verification
A read and a write can land on the same burst address in the same rising edge. The write commits its first beat on that edge and its second beat on the next one, while the read must still return the old pair. The bench first fills a known pair, then issues one reference cycle with both selects active on that address and fresh data. It checks that both returned beats equal the pre-write contents. A further read in the next cycle must then show the new data.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  typedef enum logic {
    HALF_RISE = 1'b0,
    HALF_FALL = 1'b1
  } half_e;

  localparam int DEF_ADDR_W = 4;
  localparam int DEF_LANE_W = 9;
  localparam int DEF_LANES  = 2;
endpackage

// File: rtl/ddr2b_kphase.sv
module ddr2b_kphase
  import ddr2b_pkg::*;
(
  input  logic  clk2x,
  input  logic  rst_n,
  output logic  kref,
  output half_e half
);
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) kref <= 1'b0;
    else        kref <= ~kref;
  end

  assign half = kref ? HALF_FALL : HALF_RISE;

  p_kref_toggle_r1: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> (kref != $past(kref)));
endmodule

// File: rtl/ddr2b_word_store.sv
module ddr2b_word_store #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int WORDS  = 2 ** (ADDR_W + 1)
) (
  input  logic              clk2x,
  input  logic              we,
  input  logic [ADDR_W:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe,
  input  logic [ADDR_W-1:0] rpair,
  output logic [DATA_W-1:0] rword0,
  output logic [DATA_W-1:0] rword1
);
  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk2x) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && wbe[l]) cells[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rword0 = cells[{rpair, 1'b0}];
  assign rword1 = cells[{rpair, 1'b1}];
endmodule

// File: rtl/ddr2b_wr_seq.sv
module ddr2b_wr_seq
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  half_e             half,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] burst_addr,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANES-1:0]  lane_wen_n,
  output logic              we,
  output logic [ADDR_W:0]   waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wbe
);
  logic              pend;
  logic [ADDR_W-1:0] pair_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pair_q <= '0;
    end else if (half == HALF_RISE) begin
      pend   <= ~wr_sel_n;
      pair_q <= burst_addr;
    end else begin
      pend   <= 1'b0;
    end
  end

  always_comb begin
    if (half == HALF_RISE) begin
      we    = ~wr_sel_n;
      waddr = {burst_addr, 1'b0};
    end else begin
      we    = pend;
      waddr = {pair_q, 1'b1};
    end
    wdata = wdata_in;
    wbe   = ~lane_wen_n;
  end

  p_second_beat_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
    (we && half == HALF_FALL) |-> $past(half == HALF_RISE && !wr_sel_n));
endmodule

// File: rtl/ddr2b_rd_pipe.sv
module ddr2b_rd_pipe
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  half_e             half,
  input  logic              rd_sel_n,
  input  logic [DATA_W-1:0] rword0,
  input  logic [DATA_W-1:0] rword1,
  output logic [DATA_W-1:0] q_data,
  output logic              q_oe
);
  logic              a_v, b_v;
  logic [DATA_W-1:0] a_w0, a_w1, b_w0, b_w1;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      a_v <= 1'b0;  b_v <= 1'b0;
      a_w0 <= '0;   a_w1 <= '0;
      b_w0 <= '0;   b_w1 <= '0;
      q_data <= '0; q_oe <= 1'b0;
    end else if (half == HALF_RISE) begin
      a_v  <= ~rd_sel_n;
      a_w0 <= rword0;
      a_w1 <= rword1;
      b_v  <= a_v;
      b_w0 <= a_w0;
      b_w1 <= a_w1;
      q_data <= b_w1;
      q_oe   <= b_v;
    end else begin
      q_data <= b_w0;
      q_oe   <= b_v;
    end
  end

  p_oe_start_fall_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(q_oe) |-> (half == HALF_RISE));
  p_oe_two_beats_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(q_oe) |=> q_oe);
  p_deselect_quiet_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    (half == HALF_RISE && rd_sel_n) |-> ##4 !q_oe ##1 !q_oe);
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANE_W = DEF_LANE_W,
  parameter int LANES  = DEF_LANES,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] burst_addr,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANES-1:0]  lane_wen_n,
  output logic [DATA_W-1:0] rdata_out,
  output logic              rdata_oe,
  output logic              kref
);
  half_e             half;
  logic              we;
  logic [ADDR_W:0]   waddr;
  logic [DATA_W-1:0] wdata, rword0, rword1, q_data;
  logic [LANES-1:0]  wbe;

  ddr2b_kphase u_phase (
    .clk2x(clk2x), .rst_n(rst_n), .kref(kref), .half(half)
  );

  ddr2b_wr_seq #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk2x(clk2x), .rst_n(rst_n), .half(half), .wr_sel_n(wr_sel_n),
    .burst_addr(burst_addr), .wdata_in(wdata_in), .lane_wen_n(lane_wen_n),
    .we(we), .waddr(waddr), .wdata(wdata), .wbe(wbe)
  );

  ddr2b_word_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk2x(clk2x), .we(we), .waddr(waddr), .wdata(wdata), .wbe(wbe),
    .rpair(burst_addr), .rword0(rword0), .rword1(rword1)
  );

  ddr2b_rd_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk2x(clk2x), .rst_n(rst_n), .half(half), .rd_sel_n(rd_sel_n),
    .rword0(rword0), .rword1(rword1), .q_data(q_data), .q_oe(rdata_oe)
  );

  assign rdata_out = rdata_oe ? q_data : {DATA_W{1'bz}};
endmodule

// File: tb/sim_ddr2b_sram.sv
module sim_ddr2b_sram;
  logic        clk2x = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [3:0]  burst_addr = '0;
  logic [17:0] wdata_in = '0;
  logic [1:0]  lane_wen_n = 2'b11;
  logic [17:0] rdata_out;
  logic        rdata_oe, kref;

  int checks = 0, fails = 0;
  logic [17:0] model [32];

  always #2 clk2x = ~clk2x;

  ddr2b_sram u0 (
    .clk2x(clk2x), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .burst_addr(burst_addr), .wdata_in(wdata_in), .lane_wen_n(lane_wen_n),
    .rdata_out(rdata_out), .rdata_oe(rdata_oe), .kref(kref)
  );

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] nw,
                                        input logic [1:0] wen_n);
    logic [17:0] r = old;
    if (!wen_n[0]) r[8:0]  = nw[8:0];
    if (!wen_n[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  // Called just before a rising edge; returns just before the next rising edge.
  task automatic kcycle(input logic r, input logic w, input logic [3:0] a,
                        input logic [17:0] d0, input logic [1:0] b0,
                        input logic [17:0] d1, input logic [1:0] b1);
    rd_sel_n = r; wr_sel_n = w; burst_addr = a; wdata_in = d0; lane_wen_n = b0;
    @(negedge clk2x);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; wdata_in = d1; lane_wen_n = b1;
    @(negedge clk2x);
    lane_wen_n = 2'b11;
    if (!w) begin
      model[{a, 1'b0}] = merge(model[{a, 1'b0}], d0, b0);
      model[{a, 1'b1}] = merge(model[{a, 1'b1}], d1, b1);
    end
  endtask

  // After kcycle of a read: wait through E2, E3 and check both beats.
  task automatic chk_read(input string req, input logic [17:0] e0, input logic [17:0] e1);
    @(negedge clk2x);
    chk({req, " oe low before beat0"}, {17'd0, rdata_oe}, 18'd0);
    @(negedge clk2x);
    chk({req, " oe beat0"}, {17'd0, rdata_oe}, 18'd1);
    chk({req, " beat0"}, rdata_out, e0);
    @(negedge clk2x);
    chk({req, " beat1"}, rdata_out, e1);
    @(negedge clk2x);
    chk({req, " oe off"}, {17'd0, rdata_oe}, 18'd0);
    chk({req, " float"}, rdata_out, 18'bz);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk2x);
    chk("R1 oe in reset", {17'd0, rdata_oe}, 18'd0);
    chk("R1 float in reset", rdata_out, 18'bz);
    rst_n = 1'b1;
    chk("R1 kref low", {17'd0, kref}, 18'd0);
    @(negedge clk2x);
    chk("R1 kref rises", {17'd0, kref}, 18'd1);
    @(negedge clk2x);
    chk("R1 kref falls", {17'd0, kref}, 18'd0);
  endtask

  task automatic t_fill_and_read();
    for (int i = 0; i < 16; i++)
      kcycle(1'b1, 1'b0, 4'(i), 18'h10000 + 18'(i * 37), 2'b00, 18'h08000 + 18'(i * 91), 2'b00);
    for (int i = 0; i < 16; i += 5) begin
      kcycle(1'b0, 1'b1, 4'(i), 18'h0, 2'b11, 18'h0, 2'b11);
      chk_read("R6 R10 R3 read", model[{4'(i), 1'b0}], model[{4'(i), 1'b1}]);
    end
  endtask

  task automatic t_read_deselect();
    kcycle(1'b1, 1'b1, 4'd3, 18'h0, 2'b11, 18'h0, 2'b11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk2x);
      chk("R2 no burst oe", {17'd0, rdata_oe}, 18'd0);
      chk("R2 no burst float", rdata_out, 18'bz);
    end
  endtask

  task automatic t_write_deselect();
    logic [17:0] e0 = model[{4'd6, 1'b0}], e1 = model[{4'd6, 1'b1}];
    kcycle(1'b1, 1'b1, 4'd6, 18'h3ffff, 2'b00, 18'h2aaaa, 2'b00);
    kcycle(1'b0, 1'b1, 4'd6, 18'h0, 2'b11, 18'h0, 2'b11);
    chk_read("R5 write deselect", e0, e1);
  endtask

  task automatic t_lane_masks();
    logic [17:0] e0, e1;
    kcycle(1'b1, 1'b0, 4'd7, 18'h1ffff, 2'b01, 18'h15555, 2'b10);
    e0 = model[{4'd7, 1'b0}]; e1 = model[{4'd7, 1'b1}];
    kcycle(1'b0, 1'b1, 4'd7, 18'h0, 2'b11, 18'h0, 2'b11);
    chk_read("R7 per-beat lanes", e0, e1);
  endtask

  task automatic t_full_mask();
    logic [17:0] e0 = model[{4'd9, 1'b0}], e1 = model[{4'd9, 1'b1}];
    kcycle(1'b1, 1'b0, 4'd9, 18'h3ffff, 2'b11, 18'h3ffff, 2'b11);
    kcycle(1'b0, 1'b1, 4'd9, 18'h0, 2'b11, 18'h0, 2'b11);
    chk_read("R8 fully masked", e0, e1);
  endtask

  task automatic t_collision();
    logic [17:0] o0 = model[{4'd12, 1'b0}], o1 = model[{4'd12, 1'b1}];
    kcycle(1'b0, 1'b0, 4'd12, 18'h0abcd, 2'b00, 18'h1dcba, 2'b00);
    chk_read("R9 old data on collision", o0, o1);
    kcycle(1'b0, 1'b1, 4'd12, 18'h0, 2'b11, 18'h0, 2'b11);
    chk_read("R10 new data next", 18'h0abcd, 18'h1dcba);
  endtask

  task automatic t_back_to_back();
    kcycle(1'b0, 1'b1, 4'd2, 18'h0, 2'b11, 18'h0, 2'b11);
    kcycle(1'b0, 1'b1, 4'd13, 18'h0, 2'b11, 18'h0, 2'b11);
    chk("R4 stream oe0", {17'd0, rdata_oe}, 18'd1);
    chk("R4 stream beat0", rdata_out, model[{4'd2, 1'b0}]);
    @(negedge clk2x);
    chk("R4 stream beat1", rdata_out, model[{4'd2, 1'b1}]);
    @(negedge clk2x);
    chk("R4 stream oe2", {17'd0, rdata_oe}, 18'd1);
    chk("R4 stream beat2", rdata_out, model[{4'd13, 1'b0}]);
    @(negedge clk2x);
    chk("R4 stream beat3", rdata_out, model[{4'd13, 1'b1}]);
    @(negedge clk2x);
    chk("R4 stream end", {17'd0, rdata_oe}, 18'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk2x);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_and_read();
    t_read_deselect();
    t_write_deselect();
    t_lane_masks();
    t_full_mask();
    t_collision();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule